// File: doc/BRIEF.md
# Clock Source Control and Switch

This block manages two on-chip oscillators, a fast one and a slow one, and chooses which of them clocks the system. Software reaches it through three 32-bit registers on a simple register bus. The bus has an address, a write strobe, write data and combinational read data. The analog oscillators and the glitch-free clock multiplexer sit outside the block. The fast oscillator is seen only through an enable output and a one-cycle tick input, which marks each of its cycles and is sampled in the bus clock domain. The slow oscillator is treated as always running and always ready.

Software picks a source by writing a select field. Hardware commits the switch into a status field only when the target source is ready, and drives the external multiplexer from that status. The fast oscillator's enable bit is guarded. Software cannot switch it off while the fast source is in use or is the pending target. The fast ready flag follows the enable bit after a fixed number of oscillator ticks. That count is a short one when the oscillator stops and a longer startup count when it starts.

Top module: `clk_src_switch`

## Requirements
- R1: After reset the fast enable reads 1, the fast ready flag reads 1, and the select and status fields read 000. `hsOscEn` is 1 and `sysSrcLow` is 0.
- R2: Bit 0 of offset 0x00 is the fast-oscillator enable. It is readable and writable and drives `hsOscEn`.
- R3: A write of 0 to the enable bit leaves the bit at 1 when the status field is 000 or the select field is 000. This holds even when the select write landed one cycle earlier and the switch has not yet committed.
- R4: Bit 0 of offset 0x08 is the fast ready flag and is read-only. After the enable is cleared, the flag reads 0 from the cycle after the clock edge that samples the STOP_TICKS-th tick. Cycles without a tick do not count. Re-enabling before that point restarts the count.
- R5: After the enable is set while the flag is 0, the flag reads 1 from the cycle after the edge that samples the START_TICKS-th tick.
- R6: At offset 0x0C, bits 2:0 form a read/write select field and bits 6:4 form a read-only status field. The encoding is 000 for the fast source and 001 for the slow source.
- R7: When the select field differs from the status field and the target is ready, the status field takes the select value on the clock edge after the select write. A switch to the fast source waits until its ready flag is 1.
- R8: Select codes 010 to 111 are stored and read back, but the status field keeps its value.
- R9: Bit 3 and bits 31:7 of offset 0x0C, bits 31:1 of offsets 0x00 and 0x08, and every other address read as 0. Writes to those bits or to offset 0x08 have no effect.
- R10: `sysSrcLow` is 1 exactly when the status field is 001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and control clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte offset of the register access |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data |
| hsTick | input | 1 | One-cycle pulse per fast-oscillator cycle |
| hsOscEn | output | 1 | Enable to the fast oscillator |
| sysSrcLow | output | 1 | Multiplexer select: 1 selects the slow source |

## Verification
The bench builds the block with START_TICKS set to 5 and STOP_TICKS set to 3. These short windows let it step through every tick of the start and stop sequences, reading the ready flag after each one. With windows this short it also exercises a stop sequence that is aborted and then restarted. It sweeps all eight select codes upward from the fast source and downward from the slow source, with the reserved write bits set. It covers the back-to-back case where a clear of the enable lands on the edge that would commit a pending switch to the fast source.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
  localparam int SEL_W    = 3;
  localparam int STAT_LSB = 4;
  localparam int OFF_EN   = 'h00;
  localparam int OFF_STAT = 'h08;
  localparam int OFF_CFG  = 'h0C;
  localparam logic [SEL_W-1:0] SRC_HS = 3'd0;
  localparam logic [SEL_W-1:0] SRC_LS = 3'd1;

  typedef struct packed {
    logic enWr;     // load enable bit
    logic enVal;    // value to load
    logic selWr;    // load select field
    logic statusWr; // commit select into status
    logic readyWr;  // copy enable into ready flag
  } ctlStrobes_t;
endpackage

// File: rtl/clk_src_ctl.sv
module clk_src_ctl
  import clk_src_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int START_TICKS = 16,
  parameter int STOP_TICKS  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              wrEnBit,
  input  logic              hsTick,
  input  logic              enQ,
  input  logic              readyQ,
  input  logic [SEL_W-1:0]  selQ,
  input  logic [SEL_W-1:0]  statusQ,
  output ctlStrobes_t       strobes
);
  localparam int MAX_TICKS = (START_TICKS > STOP_TICKS) ? START_TICKS : STOP_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] tickLimit;
  logic hitEn, hitCfg, guardHs, targetOk, settling, lastTick;

  assign hitEn     = busWe && (busAddr == ADDR_W'(OFF_EN));
  assign hitCfg    = busWe && (busAddr == ADDR_W'(OFF_CFG));
  assign guardHs   = (statusQ == SRC_HS) || (selQ == SRC_HS);
  assign targetOk  = (selQ == SRC_LS) || ((selQ == SRC_HS) && readyQ);
  assign settling  = (enQ != readyQ);
  assign tickLimit = enQ ? CNT_W'(START_TICKS - 1) : CNT_W'(STOP_TICKS - 1);
  assign lastTick  = settling && hsTick && (tickCnt == tickLimit);

  always_comb begin
    strobes          = '0;
    strobes.enWr     = hitEn && (wrEnBit || !guardHs);
    strobes.enVal    = wrEnBit;
    strobes.selWr    = hitCfg;
    strobes.statusWr = (selQ != statusQ) && targetOk;
    strobes.readyWr  = lastTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (!settling || lastTick) begin
      tickCnt <= '0;
    end else if (hsTick) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end
endmodule

// File: rtl/clk_src_dp.sv
module clk_src_dp
  import clk_src_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [SEL_W-1:0]  selIn,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              enQ,
  output logic              readyQ,
  output logic [SEL_W-1:0]  selQ,
  output logic [SEL_W-1:0]  statusQ,
  output logic [DATA_W-1:0] busRdata
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ     <= 1'b1;
      readyQ  <= 1'b1;
      selQ    <= SRC_HS;
      statusQ <= SRC_HS;
    end else begin
      if (strobes.enWr)     enQ     <= strobes.enVal;
      if (strobes.readyWr)  readyQ  <= enQ;
      if (strobes.selWr)    selQ    <= selIn;
      if (strobes.statusWr) statusQ <= selQ;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(OFF_EN)) begin
      busRdata[0] = enQ;
    end else if (busAddr == ADDR_W'(OFF_STAT)) begin
      busRdata[0] = readyQ;
    end else if (busAddr == ADDR_W'(OFF_CFG)) begin
      busRdata[SEL_W-1:0]          = selQ;
      busRdata[STAT_LSB +: SEL_W]  = statusQ;
    end
  end
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
  import clk_src_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int START_TICKS = 16,
  parameter int STOP_TICKS  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              hsTick,
  output logic              hsOscEn,
  output logic              sysSrcLow
);
  ctlStrobes_t      strobes;
  logic             enQ, hsReadyQ;
  logic [SEL_W-1:0] selQ, statusQ;
  logic             unusedWdata;

  assign unusedWdata = ^busWdata[31:SEL_W];

  clk_src_ctl #(
    .ADDR_W(ADDR_W), .START_TICKS(START_TICKS), .STOP_TICKS(STOP_TICKS)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .wrEnBit(busWdata[0]), .hsTick(hsTick), .enQ(enQ), .readyQ(hsReadyQ),
    .selQ(selQ), .statusQ(statusQ), .strobes(strobes)
  );

  clk_src_dp #(.ADDR_W(ADDR_W), .DATA_W(32)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .selIn(busWdata[SEL_W-1:0]),
    .busAddr(busAddr), .enQ(enQ), .readyQ(hsReadyQ), .selQ(selQ),
    .statusQ(statusQ), .busRdata(busRdata)
  );

  assign hsOscEn   = enQ;
  assign sysSrcLow = (statusQ == SRC_LS);
endmodule

// File: rtl/clk_src_switch_chk.sv
module clk_src_switch_chk
  import clk_src_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              hsTick,
  input logic              hsOscEn,
  input logic              sysSrcLow,
  input logic              hsReadyQ,
  input logic [SEL_W-1:0]  selQ,
  input logic [SEL_W-1:0]  statusQ
);
  // R3
  refuse_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(OFF_EN) && !busWdata[0] && hsOscEn &&
     (statusQ == SRC_HS || selQ == SRC_HS)) |=> hsOscEn);

  // R7
  hs_commit_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(statusQ) && statusQ == SRC_HS) |-> $past(hsReadyQ));

  // R8
  status_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusQ) |-> (statusQ == SRC_HS || statusQ == SRC_LS));

  // R5
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsReadyQ) |-> ($past(hsOscEn) && $past(hsTick)));

  // R4
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hsReadyQ) |-> (!$past(hsOscEn) && $past(hsTick)));

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdata[31:7] == '0) && !busRdata[3]);

  // R10
  src_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysSrcLow == (statusQ == SRC_LS));
endmodule

bind clk_src_switch clk_src_switch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata), .busRdata(busRdata), .hsTick(hsTick),
  .hsOscEn(hsOscEn), .sysSrcLow(sysSrcLow), .hsReadyQ(hsReadyQ),
  .selQ(selQ), .statusQ(statusQ)
);

// File: tb/test_clk_src_switch.sv
`timescale 1ns/1ps
module test_clk_src_switch;
  localparam int START = 5;
  localparam int STOP  = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        hsTick = 1'b0;
  logic        hsOscEn, sysSrcLow;
  int          nRun = 0, nFail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  clk_src_switch #(.ADDR_W(8), .START_TICKS(START), .STOP_TICKS(STOP)) i_clk_src_switch (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .hsTick(hsTick), .hsOscEn(hsOscEn), .sysSrcLow(sysSrcLow)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    busAddr = a; #1; v = busRdata;
  endtask

  task automatic tick();
    hsTick = 1'b1;
    @(negedge clk);
    hsTick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int prev;
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    rd(8'h00, v); chk("R1 enable", v, 32'h1);
    rd(8'h08, v); chk("R1 ready", v, 32'h1);
    rd(8'h0C, v); chk("R1 config", v, 32'h0);
    chk("R1 hsOscEn", {31'b0, hsOscEn}, 32'h1);
    chk("R1 sysSrcLow", {31'b0, sysSrcLow}, 32'h0);
    // R9 unmapped addresses
    rd(8'h04, v); chk("R9 addr 04", v, 32'h0);
    rd(8'h10, v); chk("R9 addr 10", v, 32'h0);
    // R3 clear refused while fast source active
    wr(8'h00, 32'hFFFF_FFFE); rd(8'h00, v); chk("R3 active", v, 32'h1);
    // R9 write to read-only status register ignored
    wr(8'h08, 32'h0); rd(8'h08, v); chk("R9 ro ready", v, 32'h1);
    // R6 R7 R8 R10 sweep of all select codes, up then down
    prev = 0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 8; i++) begin
        int c, exp;
        c = (pass == 0) ? i : 7 - i;
        wr(8'h0C, 32'hFFFF_FFF8 | c);
        rd(8'h0C, v); chk("R7 no early commit", v, (prev << 4) | c);
        exp = (c <= 1) ? c : prev;
        idle(1);
        rd(8'h0C, v); chk("R8 R6 select/status", v, (exp << 4) | c);
        chk("R10 mux select", {31'b0, sysSrcLow}, (exp == 1) ? 32'h1 : 32'h0);
        prev = exp;
      end
    end
    // R3 back-to-back: clear lands on the commit edge of a pending fast switch
    wr(8'h0C, 32'h1); idle(1);
    wr(8'h0C, 32'h0);
    wr(8'h00, 32'h0);
    rd(8'h00, v); chk("R3 pending", v, 32'h1);
    // R2 clear allowed while slow source is selected and active
    wr(8'h0C, 32'h1); idle(1);
    wr(8'h00, 32'h0);
    rd(8'h00, v); chk("R2 enable cleared", v, 32'h0);
    chk("R2 hsOscEn", {31'b0, hsOscEn}, 32'h0);
    // R4 idle cycles do not count, partial count restarts
    idle(4); rd(8'h08, v); chk("R4 no tick", v, 32'h1);
    tick(); tick(); rd(8'h08, v); chk("R4 partial", v, 32'h1);
    wr(8'h00, 32'h1); rd(8'h08, v); chk("R4 re-enabled", v, 32'h1);
    wr(8'h00, 32'h0);
    for (int n = 1; n <= STOP; n++) begin
      tick(); rd(8'h08, v);
      chk("R4 stop count", v, (n < STOP) ? 32'h1 : 32'h0);
    end
    // R7 switch to fast waits for ready
    wr(8'h0C, 32'h0); idle(2);
    rd(8'h0C, v); chk("R7 pending", v, 32'h10);
    // R5 startup count
    wr(8'h00, 32'h1);
    for (int n = 1; n <= START; n++) begin
      tick(); rd(8'h08, v);
      chk("R5 start count", v, (n < START) ? 32'h0 : 32'h1);
      rd(8'h0C, v); chk("R7 held until ready", v, 32'h10);
    end
    idle(1);
    rd(8'h0C, v); chk("R7 commit after ready", v, 32'h0);
    chk("R10 fast selected", {31'b0, sysSrcLow}, 32'h0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule